// File: doc/BRIEF.md
# Per-CPU Prefix Relocator

This block sits on one processor's path to shared storage. It turns each real address into the absolute address that reaches memory. Every processor in a multiprocessor owns a different 12-bit prefix. The relocator exchanges the lowest 4096-byte block of real storage with the block that the prefix names. Each processor therefore has a private copy of the low block, while all other storage stays shared.

One request path serves two kinds of address: those issued in real mode and those already produced by dynamic address translation. A write port loads the prefix. Requests arrive as a valid flag with a real address. The absolute address leaves through a register one clock later.

Top module: `prefix_relocator`

## Requirements
- R1: The 12 low-order address bits (the offset within a 4096-byte block) reach `rsp_addr_o` unchanged.
- R2: A real address whose upper 12 bits (block number, bits 23:12) are zero leaves with its block number replaced by the current prefix.
- R3: A real address whose block number equals the current prefix leaves with block number zero.
- R4: A real address whose block number is neither zero nor the prefix leaves unchanged.
- R5: While the prefix is zero, every address leaves unchanged.
- R6: `rsp_valid_o` equals `req_valid_i` from the previous clock edge. A request's absolute address appears exactly one cycle after the request is accepted.
- R7: After reset `rsp_valid_o` is low and the prefix is zero, so the first requests are translated as identity.
- R8: A prefix write is used for requests accepted from the next cycle onward. A request in the same cycle as the write uses the old prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pfx_we_i | input | 1 | Prefix write strobe |
| pfx_wdata_i | input | 12 | New prefix block number |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 24 | Real address |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| rsp_addr_o | output | 24 | Absolute address |

## Verification
A corrupted prefix register would not show at the ports until a request targets block zero or the prefix block. The bench therefore steers many requests into those two blocks, and steers requests into the old and new prefix blocks right after each write. A fault in the swap or the output register shows on the very next cycle as a wrong block number or a misaligned valid. Writes that coincide with requests expose any off-by-one error in when a new prefix takes effect.

// File: rtl/prefix_pkg.sv
package prefix_pkg;
  localparam int unsigned DEF_ADDR_W = 24;
  localparam int unsigned DEF_OFF_W  = 12;
endpackage

// File: rtl/prefix_reg.sv
module prefix_reg #(
  parameter int unsigned BLK_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [BLK_W-1:0] wdata_i,
  output logic [BLK_W-1:0] prefix_o
);
  logic [BLK_W-1:0] prefix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prefix_q <= '0;
    else if (we_i) prefix_q <= wdata_i;
  end

  assign prefix_o = prefix_q;

  AST_PFX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> prefix_o == $past(wdata_i)); // R8
  AST_PFX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(prefix_o)); // R8
endmodule

// File: rtl/block_swap.sv
module block_swap #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFF_W  = 12,
  localparam int unsigned BLK_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BLK_W-1:0]  prefix_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BLK_W-1:0] blk_in, blk_out;

  assign blk_in = addr_i[ADDR_W-1:OFF_W];

  // block zero checked first: with a zero prefix both rules agree
  always_comb begin
    if (blk_in == '0)            blk_out = prefix_i;
    else if (blk_in == prefix_i) blk_out = '0;
    else                         blk_out = blk_in;
  end

  assign addr_o = {blk_out, addr_i[OFF_W-1:0]};
endmodule

// File: rtl/rsp_stage.sv
module rsp_stage #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) addr_q <= addr_i;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/prefix_relocator.sv
module prefix_relocator
  import prefix_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned OFF_W  = DEF_OFF_W,
  localparam int unsigned BLK_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pfx_we_i,
  input  logic [BLK_W-1:0]  pfx_wdata_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  logic [BLK_W-1:0]  prefix;
  logic [ADDR_W-1:0] abs_addr;

  prefix_reg #(.BLK_W(BLK_W)) u_pfx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pfx_we_i),
    .wdata_i  (pfx_wdata_i),
    .prefix_o (prefix)
  );

  block_swap #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_swap (
    .addr_i   (req_addr_i),
    .prefix_i (prefix),
    .addr_o   (abs_addr)
  );

  rsp_stage #(.ADDR_W(ADDR_W)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .addr_i  (abs_addr),
    .valid_o (rsp_valid_o),
    .addr_o  (rsp_addr_o)
  );

  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i)); // R6
  AST_OFFSET_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_addr_o[OFF_W-1:0] == $past(req_addr_i[OFF_W-1:0])); // R1
  AST_LOW_TO_PFX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_addr_i[ADDR_W-1:OFF_W] == '0
    |=> rsp_addr_o[ADDR_W-1:OFF_W] == $past(prefix)); // R2
  AST_PFX_TO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_addr_i[ADDR_W-1:OFF_W] == prefix
    |=> rsp_addr_o[ADDR_W-1:OFF_W] == '0 || $past(prefix) == '0); // R3
  AST_OTHER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_addr_i[ADDR_W-1:OFF_W] != '0 && req_addr_i[ADDR_W-1:OFF_W] != prefix
    |=> rsp_addr_o == $past(req_addr_i)); // R4
  AST_ZERO_IDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && prefix == '0 |=> rsp_addr_o == $past(req_addr_i)); // R5
endmodule

// File: tb/sim_prefix_relocator.sv
module sim_prefix_relocator;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int OW = 12;
  localparam int BW = AW - OW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pfx_we = 1'b0;
  logic [BW-1:0] pfx_wdata = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [AW-1:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  logic [BW-1:0] model_pfx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefix_relocator u0 (
    .clk_i(clk), .rst_ni(rst_n), .pfx_we_i(pfx_we), .pfx_wdata_i(pfx_wdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr)
  );

  function automatic logic [AW-1:0] expect_abs(logic [AW-1:0] a, logic [BW-1:0] p);
    logic [BW-1:0] b;
    b = a[AW-1:OW];
    if (b == '0)     b = p;
    else if (b == p) b = '0;
    return {b, a[OW-1:0]};
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 time unit after the next posedge
  task automatic step(logic v, logic [AW-1:0] a, logic we, logic [BW-1:0] wd,
                      string req);
    logic [BW-1:0] p_used;
    @(negedge clk);
    req_valid = v; req_addr = a; pfx_we = we; pfx_wdata = wd;
    p_used = model_pfx;
    @(posedge clk); #1;
    if (we) model_pfx = wd;
    check({req, " valid"}, AW'(rsp_valid), AW'(v));
    if (v) check(req, rsp_addr, expect_abs(a, p_used));
    @(negedge clk);
    req_valid = 1'b0; pfx_we = 1'b0;
  endtask

  task automatic wr_pfx(logic [BW-1:0] p);
    step(1'b0, '0, 1'b1, p, "R8 write");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset valid", AW'(rsp_valid), '0);
    @(negedge clk); rst_n = 1'b1;

    // R7/R5: prefix zero after reset gives identity
    step(1'b1, 24'h000abc, 1'b0, '0, "R7 R5 block0 identity");
    step(1'b1, 24'h123456, 1'b0, '0, "R5 other identity");
    step(1'b0, 24'hffffff, 1'b0, '0, "R6 idle");

    wr_pfx(12'h2a5);
    step(1'b1, 24'h000123, 1'b0, '0, "R2 block0 to prefix");
    step(1'b1, 24'h2a5fff, 1'b0, '0, "R3 prefix to block0");
    step(1'b1, 24'h2a6000, 1'b0, '0, "R4 neighbour pass");
    step(1'b1, 24'h000000, 1'b0, '0, "R1 R2 offset zero");

    // R8: request with concurrent write uses old prefix, next uses new
    step(1'b1, 24'h000777, 1'b1, 12'h3c0, "R8 same-cycle old prefix");
    step(1'b1, 24'h000777, 1'b0, '0, "R8 next-cycle new prefix");
    step(1'b1, 24'h2a5001, 1'b0, '0, "R8 R4 old prefix block passes");
    step(1'b1, 24'h3c0001, 1'b0, '0, "R8 R3 new prefix block");

    wr_pfx(12'hfff);
    step(1'b1, 24'hfffabc, 1'b0, '0, "R3 top block");
    step(1'b1, 24'h000abc, 1'b0, '0, "R2 to top block");
    wr_pfx(12'h000);
    step(1'b1, 24'h000555, 1'b0, '0, "R5 prefix cleared");

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [BW-1:0] b;
      int sel;
      sel = $urandom_range(0, 3);
      a = AW'($urandom);
      b = (sel == 0) ? '0 : (sel == 1) ? model_pfx : a[AW-1:OW];
      a = {b, a[OW-1:0]};
      step($urandom_range(0, 4) != 0, a, $urandom_range(0, 7) == 0,
           BW'($urandom), "R1 R2 R3 R4 R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule